// File: doc/BRIEF.md
# Full-Descending Stack Pointer Unit

This block keeps a stack pointer and a small word-wide backing store that follow full-descending rules. The pointer always names the most recently written word. A push first moves the pointer down by one word (4 bytes at the default 32-bit width) and then writes the new word at that address. A pop reads the word the pointer names and then moves the pointer up by one word. Data comes back in last-in, first-out order.

One operation is accepted per clock. The caller raises `push_i` with a data word, or raises `pop_i`. The pointer and all result outputs are registered, so they change one cycle after the request. The address touched by the current request is available combinationally, for tracing. The backing store is indexed by the address bits just above the byte offset, so it acts as a window onto the pointer's address space. An occupancy count guards the window, and when an operation cannot proceed the block raises an overflow or underflow pulse instead.

Top module: `fd_stack_unit`

## Requirements
- R1: While reset is held and after it is released, `sp_o` equals the parameter `SP_RESET` (default 0x2000) and `pop_valid_o`, `overflow_o` and `underflow_o` are 0.
- R2: A push (`push_i`=1, `pop_i`=0) with fewer than `DEPTH` (64) words held drives `access_addr_o` = `sp_o`-4 in the request cycle. From the next cycle `sp_o` is that address and the word is stored there. From 0x2000, pushing 0x11 and then 0x22 leaves `sp_o` = 0x1FF8.
- R3: A pop (`pop_i`=1, `push_i`=0) with at least one word held drives `access_addr_o` = `sp_o` in the request cycle. In the next cycle `pop_valid_o`=1 for one cycle, `pop_data_o` holds the word at the old `sp_o`, and `sp_o` has risen by 4.
- R4: Popped words come back in the reverse of the order they were pushed. After the R2 trace, a pop returns 0x22 with `sp_o` = 0x1FFC, and a second pop returns 0x11.
- R5: After any sequence in which the accepted pushes and accepted pops are equal in number, `sp_o` is back at its starting value, whatever data was pushed.
- R6: A push while 64 words are held raises `overflow_o` for one cycle in the next cycle. It leaves `sp_o` unchanged and stores nothing, so the next pop still returns the previous top word.
- R7: A pop while the stack is empty raises `underflow_o` for one cycle in the next cycle. It leaves `sp_o` unchanged and `pop_valid_o` at 0.
- R8: A cycle with both `push_i` and `pop_i` high is ignored. `sp_o` is unchanged, nothing is stored, and no flag or valid pulse follows.
- R9: A cycle with neither request leaves `sp_o` unchanged, and `pop_valid_o`, `overflow_o` and `underflow_o` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| push_data_i | input | DATA_W (32) | Word to push |
| pop_data_o | output | DATA_W (32) | Popped word, meaningful while `pop_valid_o` is 1 |
| pop_valid_o | output | 1 | One-cycle strobe for a completed pop |
| sp_o | output | ADDR_W (32) | Current stack pointer |
| access_addr_o | output | ADDR_W (32) | Address written or read by the current request |
| overflow_o | output | 1 | Pulse: the previous push was refused because the stack was full |
| underflow_o | output | 1 | Pulse: the previous pop was refused because the stack was empty |

## Verification
The first pattern is a short scripted trace: two pushes and two pops from 0x2000. It confirms the direction of the pointer step and whether the pointer moves before or after the memory access. An off-by-one-word error shows up there as wrong data or a wrong address. A fill of all 64 entries, followed by one extra push and a full drain, separates correct refusal at both ends from aliasing inside the wrapped window. A long mixed stream of pushes, pops, idle cycles and simultaneous requests, drained to empty at the end, exposes lost or duplicated pointer updates through the return to the starting pointer value.

// File: rtl/fdsp_pkg.sv
package fdsp_pkg;

   // Request decode: bit 0 is push, bit 1 is pop.
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_PUSH  = 2'd1,
      OP_POP   = 2'd2,
      OP_CLASH = 2'd3
   } stk_op_e;

   function automatic stk_op_e classify(input logic push, input logic pop);
      return stk_op_e'({pop, push});
   endfunction

endpackage

// File: rtl/fdsp_ptr.sv
module fdsp_ptr
   import fdsp_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 32,
   parameter int unsigned          DEPTH    = 64,
   parameter int unsigned          STEP     = 4,
   parameter logic [ADDR_W-1:0]    SP_RESET = 'h2000,
   localparam int unsigned         CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stk_op_e           op,
   output logic [ADDR_W-1:0] sp_q,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_en_o,
   output logic              rd_en_o,
   output logic [CNT_W-1:0]  fill_o,
   output logic              ovf_q,
   output logic              unf_q
);

   logic [CNT_W-1:0]  fill_q;
   logic              full, empty, push_ok, pop_ok;
   logic [ADDR_W-1:0] sp_dn, sp_up;

   assign full    = (fill_q == CNT_W'(DEPTH));
   assign empty   = (fill_q == '0);
   assign push_ok = (op == OP_PUSH) && !full;
   assign pop_ok  = (op == OP_POP)  && !empty;
   assign sp_dn   = sp_q - ADDR_W'(STEP);
   assign sp_up   = sp_q + ADDR_W'(STEP);

   // Pushes touch the word below the pointer, pops the word under it.
   always_comb begin
      addr_o = (op == OP_PUSH) ? sp_dn : sp_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q   <= SP_RESET;
         fill_q <= '0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         if (push_ok) begin
            sp_q   <= sp_dn;
            fill_q <= fill_q + CNT_W'(1);
         end else if (pop_ok) begin
            sp_q   <= sp_up;
            fill_q <= fill_q - CNT_W'(1);
         end
         ovf_q <= (op == OP_PUSH) && full;
         unf_q <= (op == OP_POP)  && empty;
      end
   end

   assign wr_en_o = push_ok;
   assign rd_en_o = pop_ok;
   assign fill_o  = fill_q;

endmodule

// File: rtl/fdsp_store.sv
module fdsp_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] word_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (wr_en && (idx == IDX_W'(g))) begin
            word_q[g] <= wdata;
         end
      end
   end

   assign rdata = word_q[idx];

endmodule

// File: rtl/fdsp_rdport.sv
module fdsp_rdport #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data_q,
   output logic              valid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= rd_en;
   end

   if (ZERO_IDLE) begin : g_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data_q <= '0;
         else        data_q <= rd_en ? rdata : '0;
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     data_q <= '0;
         else if (rd_en) data_q <= rdata;
      end
   end

endmodule

// File: rtl/fd_stack_unit.sv
module fd_stack_unit
   import fdsp_pkg::*;
#(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       DEPTH     = 64,
   parameter logic [ADDR_W-1:0] SP_RESET  = 'h2000,
   parameter bit                ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] push_data_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              pop_valid_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic [ADDR_W-1:0] access_addr_o,
   output logic              overflow_o,
   output logic              underflow_o
);

   localparam int unsigned STEP    = DATA_W / 8;
   localparam int unsigned IDX_LSB = $clog2(STEP);
   localparam int unsigned IDX_W   = $clog2(DEPTH);
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1);

   if (DATA_W % 8 != 0 || (STEP & (STEP - 1)) != 0) begin : g_bad_width
      $error("fd_stack_unit: DATA_W must be a power-of-two number of bytes");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fd_stack_unit: DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < IDX_LSB + IDX_W) begin : g_bad_addr
      $error("fd_stack_unit: ADDR_W too narrow for the store window");
   end
   if (SP_RESET % STEP != 0) begin : g_bad_reset
      $error("fd_stack_unit: SP_RESET must be word aligned");
   end

   stk_op_e           op;
   logic              wr_en, rd_en;
   logic [CNT_W-1:0]  fill;
   logic [DATA_W-1:0] rd_word;

   assign op = classify(push_i, pop_i);

   fdsp_ptr #(
      .ADDR_W   (ADDR_W),
      .DEPTH    (DEPTH),
      .STEP     (STEP),
      .SP_RESET (SP_RESET)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .sp_q    (sp_o),
      .addr_o  (access_addr_o),
      .wr_en_o (wr_en),
      .rd_en_o (rd_en),
      .fill_o  (fill),
      .ovf_q   (overflow_o),
      .unf_q   (underflow_o)
   );

   fdsp_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk   (clk),
      .wr_en (wr_en),
      .idx   (access_addr_o[IDX_LSB +: IDX_W]),
      .wdata (push_data_i),
      .rdata (rd_word)
   );

   fdsp_rdport #(
      .DATA_W    (DATA_W),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rdata   (rd_word),
      .data_q  (pop_data_o),
      .valid_q (pop_valid_o)
   );

endmodule

// File: rtl/fd_stack_unit_sva.sv
module fdsp_checker #(
   parameter int unsigned  ADDR_W = 32,
   parameter int unsigned  DEPTH  = 64,
   parameter int unsigned  STEP   = 4,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic              pop_i,
   input logic [ADDR_W-1:0] sp_o,
   input logic              pop_valid_o,
   input logic              overflow_o,
   input logic              underflow_o,
   input logic [CNT_W-1:0]  fill
);

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && fill != CNT_W'(DEPTH)) |=> (sp_o == $past(sp_o) - ADDR_W'(STEP))); // R2

   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && fill != '0) |=> (pop_valid_o && sp_o == $past(sp_o) + ADDR_W'(STEP))); // R3

   AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && fill == CNT_W'(DEPTH)) |=> (overflow_o && $stable(sp_o))); // R6

   AST_EMPTY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && fill == '0) |=> (underflow_o && !pop_valid_o && $stable(sp_o))); // R7

   AST_CLASH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i) |=> ($stable(sp_o) && !pop_valid_o && !overflow_o && !underflow_o)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && !pop_i) |=> ($stable(sp_o) && !pop_valid_o && !overflow_o && !underflow_o)); // R9

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (fill <= CNT_W'(DEPTH))); // R6

endmodule

bind fd_stack_unit fdsp_checker #(
   .ADDR_W (ADDR_W),
   .DEPTH  (DEPTH),
   .STEP   (STEP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .sp_o        (sp_o),
   .pop_valid_o (pop_valid_o),
   .overflow_o  (overflow_o),
   .underflow_o (underflow_o),
   .fill        (fill)
);

// File: tb/sim_fd_stack_unit.sv
`timescale 1ns/1ps
module sim_fd_stack_unit;

   localparam int DEPTH = 64;
   localparam logic [31:0] START = 32'h2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 1'b0, pop_i = 1'b0;
   logic [31:0] push_data_i = '0;
   logic [31:0] pop_data_o, sp_o, access_addr_o;
   logic        pop_valid_o, overflow_o, underflow_o;

   int compared = 0;
   int mismatched = 0;

   // Reference model
   logic [31:0] model_q[$];
   logic [31:0] sp_m = START;

   always #4 clk = ~clk;

   fd_stack_unit u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .push_i        (push_i),
      .pop_i         (pop_i),
      .push_data_i   (push_data_i),
      .pop_data_o    (pop_data_o),
      .pop_valid_o   (pop_valid_o),
      .sp_o          (sp_o),
      .access_addr_o (access_addr_o),
      .overflow_o    (overflow_o),
      .underflow_o   (underflow_o)
   );

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   task automatic op(input logic p, input logic q, input logic [31:0] d);
      string       tag;
      logic        e_valid, e_ovf, e_unf;
      logic [31:0] e_data;
      @(negedge clk);
      push_i = p; pop_i = q; push_data_i = d;
      #1;
      if (p && !q) cmp("R2 addr", access_addr_o, sp_m - 32'd4);
      if (q && !p) cmp("R3 addr", access_addr_o, sp_m);
      e_valid = 1'b0; e_ovf = 1'b0; e_unf = 1'b0; e_data = '0;
      if (p && !q) begin
         if (model_q.size() == DEPTH) begin e_ovf = 1'b1; tag = "R6"; end
         else begin sp_m = sp_m - 32'd4; model_q.push_back(d); tag = "R2"; end
      end else if (q && !p) begin
         if (model_q.size() == 0) begin e_unf = 1'b1; tag = "R7"; end
         else begin e_valid = 1'b1; e_data = model_q.pop_back(); sp_m = sp_m + 32'd4; tag = "R3"; end
      end else if (p && q) tag = "R8";
      else tag = "R9";
      @(posedge clk);
      #2;
      cmp({tag, " sp"}, sp_o, sp_m);
      cmp({tag, " valid"}, {31'd0, pop_valid_o}, {31'd0, e_valid});
      cmp({tag, " overflow"}, {31'd0, overflow_o}, {31'd0, e_ovf});
      cmp({tag, " underflow"}, {31'd0, underflow_o}, {31'd0, e_unf});
      if (e_valid) cmp("R4 data", pop_data_o, e_data);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog (all R): actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp("R1 sp in reset", sp_o, START);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1 sp", sp_o, START);
      cmp("R1 flags", {29'd0, pop_valid_o, overflow_o, underflow_o}, 32'd0);

      // Scripted trace
      op(1, 0, 32'h11);
      op(1, 0, 32'h22);
      cmp("R2 trace sp", sp_o, 32'h1FF8);
      op(0, 1, 0);
      cmp("R4 trace data", pop_data_o, 32'h22);
      cmp("R4 trace sp", sp_o, 32'h1FFC);
      op(0, 1, 0);
      cmp("R4 second data", pop_data_o, 32'h11);
      cmp("R5 trace back", sp_o, START);

      // Empty stack and simultaneous requests
      op(0, 1, 0);
      op(1, 1, 32'h55);
      op(0, 1, 0);           // R8: the clashed word was not stored
      op(0, 0, 0);

      // Fill, refuse, drain
      for (int i = 0; i < DEPTH; i++) op(1, 0, 32'hA500_0000 + i * 32'h0001_0203);
      cmp("R6 full sp", sp_o, START - 32'd256);
      op(1, 0, 32'hDEAD_BEEF);
      op(1, 1, 32'hFACE_0000);
      op(0, 1, 0);           // R6: top word is still the last accepted one
      op(1, 0, 32'h1234_5678);
      while (model_q.size() > 0) op(0, 1, 0);
      op(0, 1, 0);
      cmp("R5 after drain", sp_o, START);

      // Mixed stream
      for (int i = 0; i < 400; i++) begin
         int r = $urandom_range(0, 5);
         if (r < 3)       op(1, 0, $urandom);
         else if (r < 5)  op(0, 1, 0);
         else if (i % 2)  op(1, 1, $urandom);
         else             op(0, 0, 0);
      end
      while (model_q.size() > 0) op(0, 1, 0);
      op(0, 0, 0);
      cmp("R5 mixed balanced", sp_o, START);

      summary();
      $finish;
   end

endmodule